// File: doc/BRIEF.md
# Shadowed Nonvolatile Configuration Register Bank

This block holds a small set of configuration bytes, each kept twice: a volatile working copy that drives the hardware and is returned on reads, and a modelled nonvolatile copy that supplies the working copy with its values after each power-up. It controls a row of open-collector I/O pins. One byte enables a weak pull-up per pin. One byte per pin decides whether that pin is pulled low or released. One configuration byte holds a mode bit and a read-only busy flag.

The mode bit chooses how a host write behaves. With the bit set, a write changes only the working copy, so it is immediate and can be repeated without limit. With the bit clear, the write also marks its register as pending. When the host ends the transaction, every pending register is copied into the nonvolatile store at once. The store then reports busy for a fixed number of clock cycles, and further writes are refused during that time. The serial bus is not part of the block. The host side is a byte-wide address/write/read port plus a transaction-end strobe.

A supply-good input models power. While it is low, the pins are released and writes are refused. On each rising edge of supply-good, the nonvolatile contents are copied into the working registers.

Top module: `shnv_regbank`

## Requirements
- R1: After reset, and while `supply_good` has not yet risen, `pin_pullup` and `pin_drive_low` are all zero, `nv_busy` is 0, and every mapped register reads 0x00.
- R2: In the clock edge where `supply_good` is first seen high, the nonvolatile values are copied into the working registers. From the next cycle on, reads return them. The factory values are 0x00 for the pull-up byte, 0x01 for each pin-control byte and 0x00 for the configuration byte.
- R3: Address map: 0xF0 is the pull-up byte and 0xF4+i is the control byte of pin i. 0xF2 is the configuration byte: bit 0 is the shadow-only mode bit and the only writable bit, bit 7 reads `nv_busy`, and the other bits read 0. Any other address reads 0x00, and writes to it have no effect.
- R4: Reads are combinational from `host_addr` and always return the working copy. A write becomes visible on the cycle after its clock edge.
- R5: With configuration bit 0 set to 1, a write changes only the working copy. A following `host_end` does not raise `nv_busy`, and the nonvolatile copy keeps its old value, as seen after the next power-up.
- R6: With configuration bit 0 equal to 0, a write updates the working copy at once. The nonvolatile copy is not written until `host_end`. `nv_busy` rises on the cycle after `host_end` and stays high for exactly BUSY_CYCLES cycles.
- R7: While `nv_busy` is high, host writes are ignored.
- R8: A commit copies every register written in the transaction at once. Registers not written in the transaction keep their nonvolatile values.
- R9: A write presented in the same cycle as `host_end` is included in that commit.
- R10: While `supply_good` is low, the pins are released in the same cycle and writes are ignored. Working-copy changes that were not committed are lost at the next power-up.
- R11: `pin_pullup[i]` follows bit i of the pull-up byte. `pin_drive_low[i]` is 1 when bit 0 of pin i's control byte is 0 (pull low) and 0 when that bit is 1 (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also loads the factory nonvolatile values |
| supply_good | input | 1 | High when the modelled supply is above its threshold |
| host_addr | input | 8 | Register address for reads and writes |
| host_wr | input | 1 | Write strobe for one cycle |
| host_wdata | input | 8 | Write data |
| host_end | input | 1 | End-of-transaction strobe that starts a pending commit |
| host_rdata | output | 8 | Working-copy read data for `host_addr` |
| nv_busy | output | 1 | High while a nonvolatile commit is in progress |
| pin_pullup | output | NUM_PINS | Pull-up enable per pin |
| pin_drive_low | output | NUM_PINS | Open-collector pull-low per pin |

## Verification
The assertions check, on every cycle, that the nonvolatile copy changes only in a commit cycle and that a recall loads the working copy from the nonvolatile value. They also check that a busy period starts after a commit and ends on time, that the working registers hold while busy, and that the pins are released whenever the supply is low. Only the bench's scenarios show the values that survive a power cycle. These include shadow-only writes lost against committed ones, the grouping of several writes into one commit, a write that shares its cycle with the end strobe, and the exact busy length seen at the port.

// File: rtl/shnv_pkg.sv
package shnv_pkg;
   localparam int DW = 8;
   typedef logic [DW-1:0] byte_t;

   localparam byte_t ADDR_PULLUP = 8'hF0;
   localparam byte_t ADDR_CFG    = 8'hF2;
   localparam byte_t ADDR_PIN0   = 8'hF4;

   localparam int CFG_SHADOW_BIT = 0;
   localparam int CFG_BUSY_BIT   = 7;
   localparam byte_t CFG_WMASK   = 8'h01;
endpackage

// File: rtl/shnv_slot.sv
module shnv_slot
   import shnv_pkg::*;
#(
   parameter byte_t MASK = 8'hFF,
   parameter byte_t INIT = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  recall,
   input  logic  wr_hit,
   input  byte_t wr_data,
   input  logic  sched,
   input  logic  commit,
   output byte_t shadow,
   output logic  pend_now
);
   byte_t nv;
   logic  pend_q;

   assign pend_now = pend_q | (wr_hit & sched);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         nv     <= INIT;
         pend_q <= 1'b0;
      end else if (recall) begin
         shadow <= nv;
         pend_q <= 1'b0;
      end else begin
         if (wr_hit) shadow <= wr_data & MASK;
         if (commit) begin
            if (pend_now) nv <= (wr_hit && sched) ? (wr_data & MASK) : shadow;
            pend_q <= 1'b0;
         end else if (wr_hit && sched) begin
            pend_q <= 1'b1;
         end
      end
   end

   // R8: nonvolatile copy moves only in a commit cycle
   p_nv_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(nv));
   // R2: recall loads the working copy from the stored value
   p_recall_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      recall |=> (shadow == $past(nv)));
   // R4: working copy changes only by a write or a recall
   p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall && !wr_hit) |=> $stable(shadow));
endmodule

// File: rtl/shnv_commit_timer.sv
module shnv_commit_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("shnv_commit_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (start)     cnt <= CNT_W'(CYCLES);
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   // R6: a commit raises busy on the next cycle
   p_busy_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R6: the busy period ends after its last counted cycle
   p_busy_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && cnt == CNT_W'(1)) |=> !busy);
   // R5: no busy period without a commit
   p_no_spurious_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
endmodule

// File: rtl/shnv_regbank.sv
module shnv_regbank
   import shnv_pkg::*;
#(
   parameter int    NUM_PINS    = 4,
   parameter int    BUSY_CYCLES = 1000,
   parameter byte_t PULLUP_INIT = 8'h00,
   parameter byte_t PIN_INIT    = 8'h01,
   parameter byte_t CFG_INIT    = 8'h00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                supply_good,
   input  logic [7:0]          host_addr,
   input  logic                host_wr,
   input  logic [7:0]          host_wdata,
   input  logic                host_end,
   output logic [7:0]          host_rdata,
   output logic                nv_busy,
   output logic [NUM_PINS-1:0] pin_pullup,
   output logic [NUM_PINS-1:0] pin_drive_low
);
   localparam int NREG    = NUM_PINS + 2;
   localparam int IDX_PU  = 0;
   localparam int IDX_CFG = NREG - 1;

   if (NUM_PINS < 1 || NUM_PINS > 4) begin : g_bad_pins
      $error("shnv_regbank: NUM_PINS must be 1 to 4");
   end

   logic            sg_q;
   logic            recall, live, wr_ok, shadow_en, commit;
   logic [NREG-1:0] hit, pend_vec;
   byte_t           shadow_arr [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sg_q <= 1'b0;
      else        sg_q <= supply_good;
   end

   assign recall    = supply_good & ~sg_q;
   assign live      = supply_good & sg_q;
   assign wr_ok     = host_wr & live & ~nv_busy;
   assign shadow_en = shadow_arr[IDX_CFG][CFG_SHADOW_BIT];
   assign commit    = host_end & live & ~nv_busy & (|pend_vec);

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam byte_t A    = (k == IDX_PU)  ? ADDR_PULLUP :
                               (k == IDX_CFG) ? ADDR_CFG : 8'(int'(ADDR_PIN0) + k - 1);
      localparam byte_t MSK  = (k == IDX_CFG) ? CFG_WMASK : 8'hFF;
      localparam byte_t INIV = (k == IDX_PU)  ? PULLUP_INIT :
                               (k == IDX_CFG) ? (CFG_INIT & CFG_WMASK) : PIN_INIT;

      assign hit[k] = (host_addr == A);

      shnv_slot #(.MASK(MSK), .INIT(INIV)) i_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .recall  (recall),
         .wr_hit  (wr_ok & hit[k]),
         .wr_data (host_wdata),
         .sched   (~shadow_en),
         .commit  (commit),
         .shadow  (shadow_arr[k]),
         .pend_now(pend_vec[k])
      );

      // R7: working registers hold during a commit
      p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (nv_busy && !recall) |=> $stable(shadow_arr[k]));
   end

   shnv_commit_timer #(.CYCLES(BUSY_CYCLES)) i_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(commit),
      .busy (nv_busy)
   );

   always_comb begin
      host_rdata = '0;
      for (int k = 0; k < NREG; k++) begin
         if (hit[k]) host_rdata = shadow_arr[k];
      end
      if (hit[IDX_CFG]) host_rdata[CFG_BUSY_BIT] = nv_busy;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_pullup[p]    = live & shadow_arr[IDX_PU][p];
      assign pin_drive_low[p] = live & ~shadow_arr[1 + p][0];
   end

   // R10: pins released whenever the supply is low
   p_pins_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_good |-> (pin_pullup == '0 && pin_drive_low == '0));
   // R10: a supply drop blocks any commit start
   p_no_commit_unpowered_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_good && !nv_busy) |=> !nv_busy);
endmodule

// File: tb/test_shnv_regbank.sv
`timescale 1ns/100ps
module test_shnv_regbank;
   localparam int NP   = 4;
   localparam int BUSY = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_good = 1'b0;
   logic [7:0]    host_addr = 8'h00;
   logic          host_wr = 1'b0;
   logic [7:0]    host_wdata = 8'h00;
   logic          host_end = 1'b0;
   logic [7:0]    host_rdata;
   logic          nv_busy;
   logic [NP-1:0] pin_pullup, pin_drive_low;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   shnv_regbank #(.NUM_PINS(NP), .BUSY_CYCLES(BUSY)) i_shnv_regbank (
      .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_end(host_end), .host_rdata(host_rdata), .nv_busy(nv_busy),
      .pin_pullup(pin_pullup), .pin_drive_low(pin_drive_low)
   );

   typedef enum int {K_RD, K_PU, K_DL, K_BZ} kind_t;
   typedef struct {
      kind_t      kind;
      logic [7:0] exp;
      string      req;
   } item_t;
   item_t sb[$];

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: compares queued expectations one step after the clock edge
   initial forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         case (it.kind)
            K_RD:    check(it.req, "rdata", host_rdata, it.exp);
            K_PU:    check(it.req, "pullup", 8'(pin_pullup), it.exp);
            K_DL:    check(it.req, "drive_low", 8'(pin_drive_low), it.exp);
            default: check(it.req, "busy", 8'(nv_busy), it.exp);
         endcase
      end
   end

   task automatic exp_rd(logic [7:0] a, logic [7:0] e, string req);
      @(negedge clk);
      host_addr = a;
      host_wr   = 1'b0;
      sb.push_back('{K_RD, e, req});
   endtask

   task automatic exp_pins(logic [7:0] pu, logic [7:0] dl, string req);
      @(negedge clk);
      sb.push_back('{K_PU, pu, req});
      sb.push_back('{K_DL, dl, req});
   endtask

   task automatic exp_busy(logic b, string req);
      @(negedge clk);
      sb.push_back('{K_BZ, 8'(b), req});
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d, logic fin);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1; host_end = fin;
      @(negedge clk);
      host_wr = 1'b0; host_end = 1'b0;
   endtask

   task automatic end_xfer();
      @(negedge clk);
      host_end = 1'b1;
      @(negedge clk);
      host_end = 1'b0;
   endtask

   // called at the negedge where busy should first show
   task automatic count_busy(string req);
      int n = 0;
      while (nv_busy && n < 10 * BUSY) begin
         n++;
         @(negedge clk);
      end
      check(req, "busy_len", 8'(n), 8'(BUSY));
   endtask

   task automatic power_cycle(logic wr_low);
      @(negedge clk);
      supply_good = 1'b0;
      sb.push_back('{K_PU, 8'h00, "R10"});
      sb.push_back('{K_DL, 8'h00, "R10"});
      if (wr_low) wr(8'hF5, 8'h00, 1'b1);
      @(negedge clk);
      supply_good = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state before power
      exp_rd(8'hF0, 8'h00, "R1");
      exp_rd(8'hF4, 8'h00, "R1");
      exp_pins(8'h00, 8'h00, "R1");
      exp_busy(1'b0, "R1");
      // R2: first power-up recalls factory values
      @(negedge clk); supply_good = 1'b1;
      @(negedge clk); @(negedge clk);
      exp_rd(8'hF0, 8'h00, "R2");
      for (int i = 0; i < NP; i++) exp_rd(8'(8'hF4 + i), 8'h01, "R2");
      exp_rd(8'hF2, 8'h00, "R2");
      exp_pins(8'h00, 8'h00, "R2");
      // R6 / R11: commit mode, immediate working copy, no busy before end
      wr(8'hF4, 8'h00, 1'b0);
      exp_rd(8'hF4, 8'h00, "R6");
      exp_pins(8'h00, 8'h01, "R11");
      exp_busy(1'b0, "R6");
      wr(8'hF0, 8'h05, 1'b0);
      exp_pins(8'h05, 8'h01, "R11");
      end_xfer();
      count_busy("R6");
      // R8 / R10: power cycle keeps committed values, unwritten ones kept,
      // a write while unpowered is ignored
      power_cycle(1'b1);
      exp_rd(8'hF4, 8'h00, "R8");
      exp_rd(8'hF0, 8'h05, "R8");
      exp_rd(8'hF5, 8'h01, "R10");
      exp_rd(8'hF6, 8'h01, "R8");
      exp_busy(1'b0, "R10");
      // R3: unmapped addresses
      exp_rd(8'hF1, 8'h00, "R3");
      exp_rd(8'hF3, 8'h00, "R3");
      exp_rd(8'hF8, 8'h00, "R3");
      wr(8'hF1, 8'hFF, 1'b0);
      exp_rd(8'hF1, 8'h00, "R3");
      // R3: configuration keeps only bit 0; commit it
      wr(8'hF2, 8'hFF, 1'b0);
      exp_rd(8'hF2, 8'h01, "R3");
      end_xfer();
      // R7: write during busy ignored; R3 busy bit readable
      wr(8'hF6, 8'h00, 1'b0);
      exp_rd(8'hF6, 8'h01, "R7");
      exp_rd(8'hF2, 8'h81, "R3");
      while (nv_busy) @(negedge clk);
      exp_rd(8'hF2, 8'h01, "R3");
      // R5: shadow-only writes
      wr(8'hF6, 8'h00, 1'b0);
      wr(8'hF7, 8'h00, 1'b0);
      exp_pins(8'h05, 8'h0D, "R5");
      end_xfer();
      exp_busy(1'b0, "R5");
      exp_busy(1'b0, "R5");
      power_cycle(1'b0);
      exp_rd(8'hF6, 8'h01, "R5");
      exp_rd(8'hF7, 8'h01, "R5");
      exp_rd(8'hF2, 8'h01, "R5");
      exp_rd(8'hF4, 8'h00, "R5");
      // R9: write together with end strobe
      wr(8'hF2, 8'h00, 1'b0);
      wr(8'hF7, 8'h00, 1'b1);
      count_busy("R9");
      power_cycle(1'b0);
      exp_rd(8'hF7, 8'h00, "R9");
      exp_rd(8'hF2, 8'h01, "R5");
      // R10: uncommitted commit-mode write lost at power-up
      wr(8'hF2, 8'h00, 1'b0);
      wr(8'hF0, 8'h0A, 1'b0);
      exp_rd(8'hF0, 8'h0A, "R10");
      power_cycle(1'b0);
      exp_rd(8'hF0, 8'h05, "R10");
      exp_busy(1'b0, "R10");
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule